// File: doc/BRIEF.md
# Immediate and Operand Prefix Combiner

This stage sits between an instruction decoder and the execute stage. It folds prefix words into the instruction that follows them, so the stages after it never see a prefix. There are two kinds of prefix. An immediate prefix carries ten bits that become the upper part of the next instruction's immediate. An operand prefix carries two or three register operands that are joined to the next register-form word, giving one wide instruction with up to six operands.

Words arrive already split into fields: form, opcode, extra opcode bit, immediate, three operand fields and an operand count. Input and output each use a valid/ready handshake. A prefix word is taken in and remembered, and it produces no output. The next ordinary word leaves through a one-entry output register. Its immediate has been widened, or its operand slots have been filled out, or it passes through unchanged when no matching prefix is pending. A flush drops the pending prefix and any held output.

Top module: `pfx_combiner`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and no prefix is pending.
- R2: An immediate prefix is a long-immediate word (in_kind 01) whose opcode bits [5:0] are 111100. An operand prefix is a register word (in_kind bit 1 set) with in_nops of 2 or 3 and opcode bits [4:0] equal to 11111. Either prefix is accepted and produces no output word.
- R3: A short-immediate word (in_kind 00) uses only in_imm[5:0]. If an immediate prefix is pending, out_imm = prefix*64 + in_imm[5:0] and out_wide = 1.
- R4: A long-immediate word (in_kind 01) that follows a pending immediate prefix gives out_imm = prefix*1024 + in_imm and out_wide = 1.
- R5: With no immediate prefix pending, an immediate word's value is zero-extended into out_imm and out_wide = 0. Register words always give out_imm = 0 and out_wide = 0.
- R6: The word's own operands occupy slots 0..2 of out_ops, with slot k at bits [4k+3:4k]. Slot k is filled, and out_opmask bit k is set, only when k < in_nops. Unused slots read 0.
- R7: A pending operand prefix followed by a register word fills slots 3..(2+prefix count) from the prefix operands, sets the matching out_opmask bits 3..5, and sets out_ext = 1.
- R8: out_pfx_bit carries the prefix's extra opcode bit only when the operand prefix had two operands. It is 0 for a three-operand prefix and 0 when out_ext is 0.
- R9: An operand prefix followed by a 0-operand register word gives an instruction whose only operands are the prefix's (out_opmask = 111000 for three operands).
- R10: Only one prefix is pending at a time. A newly accepted prefix of either kind replaces whatever was pending.
- R11: A pending prefix whose kind does not fit the next word is discarded. That word is emitted unchanged: an immediate prefix before a register word, or an operand prefix before an immediate word. The word after it sees no prefix.
- R12: flush clears out_valid and the pending prefix on the next edge, and in_ready is 0 while flush is high.
- R13: While out_valid = 1 and out_ready = 0, in_ready is 0 and all output fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drop pending prefix and held output |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can take a word |
| in_kind | input | 2 | 00 short immediate, 01 long immediate, 1x register form |
| in_opcode | input | OPC_W | Decoded opcode bits |
| in_xbit | input | 1 | Extra opcode bit of register forms |
| in_imm | input | LONG_W | Immediate field |
| in_ops | input | 3*REG_W | Three operand register numbers |
| in_nops | input | 2 | Number of valid operands (0..3) |
| out_valid | output | 1 | Output instruction valid |
| out_ready | input | 1 | Downstream takes the instruction |
| out_kind | output | 2 | Form of the emitted word |
| out_opcode | output | OPC_W | Opcode of the emitted word |
| out_xbit | output | 1 | Extra opcode bit of the emitted word |
| out_imm | output | PFX_W+LONG_W | Widened unsigned immediate |
| out_wide | output | 1 | Immediate received prefix bits |
| out_ext | output | 1 | Operand prefix merged |
| out_pfx_bit | output | 1 | Extra opcode bit of a two-operand prefix |
| out_opmask | output | 6 | Valid operand slots |
| out_ops | output | 6*REG_W | Six operand slots |

## Verification
Short immediates are swept over all 64 values, with nonzero bits placed above bit 5, under several prefix values. This separates correct concatenation from shifting by the wrong amount and from leaking the unused upper bits. Long immediates are swept in coarse steps with and without a prefix, which shows whether the ten prefix bits land above all ten word bits. Operand merges combine every word operand count with two- and three-operand prefixes and varied register numbers, which checks slot placement, the masks and the extra bit. Prefix pairs, mismatched pairs, flush and a held output under backpressure show whether the pending state is cleared and replaced at the right word.

// File: rtl/pfx_pkg.sv
// Shared types for the prefix combiner.
// Assumes: one pending prefix slot; each word carries at most three operands.
package pfx_pkg;
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_IMM  = 2'd1,
        PEND_OPD  = 2'd2
    } pend_e;

    localparam int unsigned SLOTS_PER_WORD = 3;
endpackage

// File: rtl/pfx_classify.sv
// Classifies an incoming decoded word as immediate prefix, operand prefix,
// register form or immediate form.
// Assumes: OPC_W >= 6; register forms keep their opcode in bits [4:0].
module pfx_classify #(
    parameter int         OPC_W    = 8,
    parameter logic [5:0] IMM_CODE = 6'b111100,
    parameter logic [4:0] OPD_CODE = 5'b11111
) (
    input  logic [1:0]       kind,
    input  logic [OPC_W-1:0] opcode,
    input  logic [1:0]       nops,
    output logic             is_reg,
    output logic             is_long,
    output logic             is_imm_pfx,
    output logic             is_opd_pfx,
    output logic             is_pfx
);
    // Decode the form bits and the two prefix codes.
    always_comb begin
        is_reg     = kind[1];
        is_long    = (kind == 2'b01);
        is_imm_pfx = is_long && (opcode[5:0] == IMM_CODE);
        is_opd_pfx = is_reg && (nops >= 2'd2) && (opcode[4:0] == OPD_CODE);
        is_pfx     = is_imm_pfx || is_opd_pfx;
    end
endmodule

// File: rtl/pfx_hold.sv
// Holds the single pending prefix (immediate bits or operand set).
// Assumes: take and consume strobes are mutually exclusive per cycle.
module pfx_hold
    import pfx_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int PFX_W = 10,
    parameter int OPS_W = 3 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             take_imm,
    input  logic             take_opd,
    input  logic             consume,
    input  logic [PFX_W-1:0] new_imm,
    input  logic [OPS_W-1:0] new_ops,
    input  logic [1:0]       new_nops,
    input  logic             new_xbit,
    output pend_e            pend,
    output logic [PFX_W-1:0] hold_imm,
    output logic [OPS_W-1:0] hold_ops,
    output logic [1:0]       hold_nops,
    output logic             hold_xbit
);
    // Track which prefix kind is pending; a new prefix replaces the old one.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= PEND_NONE;
        else if (flush)    pend <= PEND_NONE;
        else if (take_imm) pend <= PEND_IMM;
        else if (take_opd) pend <= PEND_OPD;
        else if (consume)  pend <= PEND_NONE;
    end

    // Capture the immediate prefix bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_imm <= '0;
        else if (take_imm) hold_imm <= new_imm;
    end

    // Capture the operand prefix fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_ops  <= '0;
            hold_nops <= '0;
            hold_xbit <= 1'b0;
        end else if (take_opd) begin
            hold_ops  <= new_ops;
            hold_nops <= new_nops;
            hold_xbit <= new_xbit;
        end
    end
endmodule

// File: rtl/pfx_merge.sv
// Combines the pending prefix with the current ordinary word.
// Assumes: word operands go to slots 0..2, prefix operands to slots 3..5.
module pfx_merge
    import pfx_pkg::*;
#(
    parameter int REG_W   = 4,
    parameter int SHORT_W = 6,
    parameter int LONG_W  = 10,
    parameter int PFX_W   = 10,
    parameter int WIDE_W  = PFX_W + LONG_W,
    parameter int OPS_W   = 3 * REG_W,
    parameter int NSLOT   = 2 * SLOTS_PER_WORD
) (
    input  pend_e                  pend,
    input  logic [PFX_W-1:0]       hold_imm,
    input  logic [OPS_W-1:0]       hold_ops,
    input  logic [1:0]             hold_nops,
    input  logic                   hold_xbit,
    input  logic                   is_reg,
    input  logic                   is_long,
    input  logic [LONG_W-1:0]      w_imm,
    input  logic [OPS_W-1:0]       w_ops,
    input  logic [1:0]             w_nops,
    output logic [WIDE_W-1:0]      m_imm,
    output logic                   m_wide,
    output logic                   m_ext,
    output logic                   m_pfx_bit,
    output logic [NSLOT-1:0]       m_mask,
    output logic [NSLOT*REG_W-1:0] m_ops
);
    logic               imm_pend;
    logic [SHORT_W-1:0] short_lo;

    // Decide which prefix applies to this word.
    always_comb begin
        imm_pend  = (pend == PEND_IMM);
        m_ext     = (pend == PEND_OPD) && is_reg;
        m_wide    = imm_pend && !is_reg;
        m_pfx_bit = m_ext && (hold_nops == 2'd2) && hold_xbit;
    end

    // Build the zero-extended, possibly widened immediate.
    always_comb begin
        short_lo = w_imm[SHORT_W-1:0];
        if (is_reg)
            m_imm = '0;
        else if (is_long)
            m_imm = imm_pend ? {hold_imm, w_imm} : WIDE_W'(w_imm);
        else
            m_imm = imm_pend ? WIDE_W'({hold_imm, short_lo}) : WIDE_W'(short_lo);
    end

    // Place word operands low and prefix operands high, one slot per register.
    for (genvar i = 0; i < SLOTS_PER_WORD; i++) begin : g_slot
        logic w_on;
        logic p_on;
        assign w_on = is_reg && (w_nops > 2'(i));
        assign p_on = m_ext && (hold_nops > 2'(i));
        assign m_mask[i]                   = w_on;
        assign m_mask[i + SLOTS_PER_WORD]  = p_on;
        assign m_ops[i*REG_W +: REG_W]     = w_on ? w_ops[i*REG_W +: REG_W] : '0;
        assign m_ops[(i + SLOTS_PER_WORD)*REG_W +: REG_W] =
            p_on ? hold_ops[i*REG_W +: REG_W] : '0;
    end
endmodule

// File: rtl/pfx_outreg.sv
// One-entry output register with valid/ready on both sides.
// Assumes: prefix words are accepted but never loaded into the register.
module pfx_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic              is_pfx,
    input  logic [DATA_W-1:0] d,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              accept,
    output logic              out_valid,
    output logic [DATA_W-1:0] q
);
    logic load;

    // Accept when the register is empty or being drained, never during flush.
    always_comb begin
        in_ready = !flush && (!out_valid || out_ready);
        accept   = in_valid && in_ready;
        load     = accept && !is_pfx;
    end

    // Valid flag: set on load, cleared on drain or flush.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (flush)     out_valid <= 1'b0;
        else if (load)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Data register: loaded only with ordinary words.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/pfx_combiner.sv
// Top of the prefix combiner: classifies words, holds the pending prefix,
// merges it into the next word and registers the result.
// Assumes: decoder supplies split fields; immediates are unsigned.
module pfx_combiner
    import pfx_pkg::*;
#(
    parameter int         OPC_W    = 8,
    parameter int         REG_W    = 4,
    parameter int         SHORT_W  = 6,
    parameter int         LONG_W   = 10,
    parameter int         PFX_W    = 10,
    parameter logic [5:0] IMM_CODE = 6'b111100,
    parameter logic [4:0] OPD_CODE = 5'b11111
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [1:0]              in_kind,
    input  logic [OPC_W-1:0]        in_opcode,
    input  logic                    in_xbit,
    input  logic [LONG_W-1:0]       in_imm,
    input  logic [3*REG_W-1:0]      in_ops,
    input  logic [1:0]              in_nops,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [1:0]              out_kind,
    output logic [OPC_W-1:0]        out_opcode,
    output logic                    out_xbit,
    output logic [PFX_W+LONG_W-1:0] out_imm,
    output logic                    out_wide,
    output logic                    out_ext,
    output logic                    out_pfx_bit,
    output logic [5:0]              out_opmask,
    output logic [6*REG_W-1:0]      out_ops
);
    localparam int WIDE_W = PFX_W + LONG_W;
    localparam int OPS_W  = SLOTS_PER_WORD * REG_W;
    localparam int NSLOT  = 2 * SLOTS_PER_WORD;
    localparam int DATA_W = 2 + OPC_W + 1 + WIDE_W + 3 + NSLOT + NSLOT * REG_W;

    logic is_reg, is_long, is_imm_pfx, is_opd_pfx, is_pfx;
    logic accept;
    pend_e pend;
    logic [PFX_W-1:0]       hold_imm;
    logic [OPS_W-1:0]       hold_ops;
    logic [1:0]             hold_nops;
    logic                   hold_xbit;
    logic [WIDE_W-1:0]      m_imm;
    logic                   m_wide, m_ext, m_pfx_bit;
    logic [NSLOT-1:0]       m_mask;
    logic [NSLOT*REG_W-1:0] m_ops;
    logic [DATA_W-1:0]      d_word, q_word;

    pfx_classify #(
        .OPC_W(OPC_W), .IMM_CODE(IMM_CODE), .OPD_CODE(OPD_CODE)
    ) u_cls (
        .kind(in_kind), .opcode(in_opcode), .nops(in_nops),
        .is_reg(is_reg), .is_long(is_long),
        .is_imm_pfx(is_imm_pfx), .is_opd_pfx(is_opd_pfx), .is_pfx(is_pfx)
    );

    pfx_hold #(.REG_W(REG_W), .PFX_W(PFX_W), .OPS_W(OPS_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .take_imm(accept && is_imm_pfx),
        .take_opd(accept && is_opd_pfx),
        .consume(accept && !is_pfx),
        .new_imm(in_imm), .new_ops(in_ops), .new_nops(in_nops), .new_xbit(in_xbit),
        .pend(pend), .hold_imm(hold_imm), .hold_ops(hold_ops),
        .hold_nops(hold_nops), .hold_xbit(hold_xbit)
    );

    pfx_merge #(
        .REG_W(REG_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W), .PFX_W(PFX_W),
        .WIDE_W(WIDE_W), .OPS_W(OPS_W), .NSLOT(NSLOT)
    ) u_merge (
        .pend(pend), .hold_imm(hold_imm), .hold_ops(hold_ops),
        .hold_nops(hold_nops), .hold_xbit(hold_xbit),
        .is_reg(is_reg), .is_long(is_long),
        .w_imm(in_imm), .w_ops(in_ops), .w_nops(in_nops),
        .m_imm(m_imm), .m_wide(m_wide), .m_ext(m_ext), .m_pfx_bit(m_pfx_bit),
        .m_mask(m_mask), .m_ops(m_ops)
    );

    // Pack the merged word for the output register.
    assign d_word = {in_kind, in_opcode, in_xbit, m_imm, m_wide, m_ext, m_pfx_bit,
                     m_mask, m_ops};

    pfx_outreg #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .is_pfx(is_pfx), .d(d_word), .out_ready(out_ready),
        .in_ready(in_ready), .accept(accept), .out_valid(out_valid), .q(q_word)
    );

    // Unpack the registered word onto the output ports.
    assign {out_kind, out_opcode, out_xbit, out_imm, out_wide, out_ext, out_pfx_bit,
            out_opmask, out_ops} = q_word;
endmodule

// File: rtl/pfx_combiner_chk.sv
// Assertion checker for pfx_combiner, attached with bind.
// Assumes: same parameters as the bound instance.
module pfx_combiner_chk #(
    parameter int         OPC_W    = 8,
    parameter int         REG_W    = 4,
    parameter int         LONG_W   = 10,
    parameter int         PFX_W    = 10,
    parameter logic [5:0] IMM_CODE = 6'b111100,
    parameter logic [4:0] OPD_CODE = 5'b11111
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [1:0]              in_kind,
    input logic [OPC_W-1:0]        in_opcode,
    input logic [1:0]              in_nops,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [1:0]              out_kind,
    input logic [PFX_W+LONG_W-1:0] out_imm,
    input logic                    out_wide,
    input logic                    out_ext,
    input logic                    out_pfx_bit,
    input logic [5:0]              out_opmask,
    input logic [6*REG_W-1:0]      out_ops
);
    logic pfx_fire;
    // Independent view of a prefix word being taken in.
    assign pfx_fire = in_valid && in_ready &&
        (((in_kind == 2'b01) && (in_opcode[5:0] == IMM_CODE)) ||
         (in_kind[1] && (in_nops >= 2'd2) && (in_opcode[4:0] == OPD_CODE)));

    assert_reset_idle_R1: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);

    assert_prefix_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_fire |=> !out_valid);

    assert_wide_is_imm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wide) |-> (!out_kind[1] && out_opmask == 6'd0));

    assert_plain_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide && !out_kind[1]) |-> (out_imm[PFX_W+LONG_W-1:LONG_W] == '0));

    assert_ext_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ext) |-> (out_kind[1] && out_opmask[3] && out_opmask[4]));

    assert_pfx_bit_two_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pfx_bit) |-> (out_ext && !out_opmask[5]));

    assert_flush_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    assert_stall_no_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
        (out_valid && $stable(out_imm) && $stable(out_ops) && $stable(out_opmask)));
endmodule

bind pfx_combiner pfx_combiner_chk #(
    .OPC_W(OPC_W), .REG_W(REG_W), .LONG_W(LONG_W), .PFX_W(PFX_W),
    .IMM_CODE(IMM_CODE), .OPD_CODE(OPD_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_opcode(in_opcode), .in_nops(in_nops),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_imm(out_imm), .out_wide(out_wide), .out_ext(out_ext),
    .out_pfx_bit(out_pfx_bit), .out_opmask(out_opmask), .out_ops(out_ops)
);

// File: tb/test_pfx_combiner.sv
`timescale 1ns/1ps
module test_pfx_combiner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = 2'b00;
    logic [7:0]  in_opcode = 8'h00;
    logic        in_xbit = 1'b0;
    logic [9:0]  in_imm = '0;
    logic [11:0] in_ops = '0;
    logic [1:0]  in_nops = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_kind;
    logic [7:0]  out_opcode;
    logic        out_xbit;
    logic [19:0] out_imm;
    logic        out_wide, out_ext, out_pfx_bit;
    logic [5:0]  out_opmask;
    logic [23:0] out_ops;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfx_combiner i_pfx_combiner (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_opcode(in_opcode), .in_xbit(in_xbit), .in_imm(in_imm),
        .in_ops(in_ops), .in_nops(in_nops), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_opcode(out_opcode), .out_xbit(out_xbit),
        .out_imm(out_imm), .out_wide(out_wide), .out_ext(out_ext),
        .out_pfx_bit(out_pfx_bit), .out_opmask(out_opmask), .out_ops(out_ops)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] obs();
        return {10'd0, out_valid, out_wide, out_ext, out_pfx_bit, out_opmask, out_ops, out_imm};
    endfunction

    function automatic logic [63:0] mk(input logic w, input logic e, input logic pb,
                                       input logic [5:0] mask, input logic [23:0] ops,
                                       input logic [19:0] imm);
        return {10'd0, 1'b1, w, e, pb, mask, ops, imm};
    endfunction

    // Keep only the first n operands of a three-slot field.
    function automatic logic [11:0] keep(input logic [11:0] ops, input int n);
        logic [11:0] r = '0;
        for (int i = 0; i < n; i++) r[i*4 +: 4] = ops[i*4 +: 4];
        return r;
    endfunction

    function automatic logic [2:0] lowmask(input int n);
        return 3'((1 << n) - 1);
    endfunction

    task automatic send(input logic [1:0] k, input logic [7:0] opc, input logic [9:0] imm,
                        input logic [11:0] ops, input logic [1:0] n, input logic xb);
        @(negedge clk);
        in_kind = k; in_opcode = opc; in_imm = imm; in_ops = ops; in_nops = n; in_xbit = xb;
        in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic imm_pfx(input logic [9:0] p);
        send(2'b01, 8'h3C, p, 12'h000, 2'd0, 1'b0);
    endtask

    task automatic opd_pfx(input logic [11:0] ops, input logic [1:0] n, input logic xb);
        send(2'b10, 8'h1F, 10'h000, ops, n, xb);
    endtask

    task automatic short_w(input logic [5:0] v);
        send(2'b00, 8'h07, {4'b1011, v}, 12'hABC, 2'd3, 1'b0);
    endtask

    task automatic long_w(input logic [9:0] v);
        send(2'b01, 8'h09, v, 12'h123, 2'd2, 1'b0);
    endtask

    task automatic reg_w(input logic [11:0] ops, input logic [1:0] n);
        send(2'b10, 8'h12, 10'h2AB, ops, n, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] wo, po;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        short_w(6'd9);
        chk("R1 no pending prefix", obs(), mk(0, 0, 0, 6'd0, 24'd0, 20'd9));

        // R5: plain short immediates, all values, upper bits ignored
        for (int v = 0; v < 64; v++) begin
            short_w(6'(v));
            chk("R5 short plain", obs(), mk(0, 0, 0, 6'd0, 24'd0, 20'(v)));
        end
        // R5: plain long immediates
        for (int v = 0; v < 1024; v += 37) begin
            long_w(10'(v));
            chk("R5 long plain", obs(), mk(0, 0, 0, 6'd0, 24'd0, 20'(v)));
        end

        // R2, R3: immediate prefix then short immediate
        for (int pi = 0; pi < 5; pi++) begin
            int p;
            p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 341 : (pi == 3) ? 512 : 1023;
            for (int v = 0; v < 64; v++) begin
                imm_pfx(10'(p));
                chk("R2 imm prefix silent", 64'(out_valid), 64'd0);
                short_w(6'(v));
                chk("R3 short widened", obs(), mk(1, 0, 0, 6'd0, 24'd0, 20'(p * 64 + v)));
            end
        end

        // R4: immediate prefix then long immediate
        for (int p = 0; p < 1024; p += 131) begin
            for (int v = 5; v < 1024; v += 201) begin
                imm_pfx(10'(p));
                long_w(10'(v));
                chk("R4 long widened", obs(), mk(1, 0, 0, 6'd0, 24'd0, 20'(p * 1024 + v)));
            end
        end

        // R6: register words without prefix, every operand count
        for (int n = 0; n < 4; n++) begin
            for (int a = 0; a < 12; a += 5) begin
                wo = {4'((a + 3) % 12), 4'((a + 7) % 12), 4'(a)};
                reg_w(wo, 2'(n));
                chk("R6 word slots", obs(), mk(0, 0, 0, {3'b000, lowmask(n)},
                                               {12'd0, keep(wo, n)}, 20'd0));
            end
        end

        // R7, R8: three-operand prefix merged with each word count
        for (int n = 0; n < 4; n++) begin
            for (int a = 0; a < 12; a++) begin
                wo = {4'((a + 5) % 12), 4'(11 - a), 4'(a)};
                po = {4'((a * 7) % 12), 4'((a + 1) % 12), 4'((a * 5 + 2) % 12)};
                opd_pfx(po, 2'd3, 1'b1);
                chk("R2 opd prefix silent", 64'(out_valid), 64'd0);
                reg_w(wo, 2'(n));
                chk("R7 merged operands", obs(), mk(0, 1, 0, {3'b111, lowmask(n)},
                                                    {po, keep(wo, n)}, 20'd0));
            end
        end

        // R8: two-operand prefix carries its extra bit
        for (int xb = 0; xb < 2; xb++) begin
            po = 12'h0B4;
            opd_pfx(po, 2'd2, 1'(xb));
            reg_w(12'h321, 2'd1);
            chk("R8 two-op prefix bit", obs(), mk(0, 1, 1'(xb), 6'b011001,
                                                  {keep(po, 2), 12'h001}, 20'd0));
        end

        // R9: operand prefix supplies all operands of a 0-operand word
        opd_pfx(12'h9A5, 2'd3, 1'b0);
        reg_w(12'hFFF, 2'd0);
        chk("R9 zero-operand word", obs(), mk(0, 1, 0, 6'b111000, {12'h9A5, 12'h000}, 20'd0));
        opd_pfx(12'h0A5, 2'd2, 1'b1);
        reg_w(12'hFFF, 2'd0);
        chk("R9 two-op rare form", obs(), mk(0, 1, 1, 6'b011000, {12'h0A5, 12'h000}, 20'd0));

        // R10: replacement of pending prefix
        imm_pfx(10'd3);
        imm_pfx(10'd700);
        short_w(6'd17);
        chk("R10 imm replaced", obs(), mk(1, 0, 0, 6'd0, 24'd0, 20'(700 * 64 + 17)));
        opd_pfx(12'h111, 2'd3, 1'b0);
        opd_pfx(12'h2A6, 2'd3, 1'b0);
        reg_w(12'h004, 2'd1);
        chk("R10 opd replaced", obs(), mk(0, 1, 0, 6'b111001, {12'h2A6, 12'h004}, 20'd0));
        imm_pfx(10'd5);
        opd_pfx(12'h123, 2'd3, 1'b0);
        short_w(6'd2);
        chk("R10 opd displaces imm", obs(), mk(0, 0, 0, 6'd0, 24'd0, 20'd2));
        opd_pfx(12'h123, 2'd3, 1'b0);
        imm_pfx(10'd6);
        reg_w(12'h005, 2'd1);
        chk("R10 imm displaces opd", obs(), mk(0, 0, 0, 6'b000001, 24'h000005, 20'd0));

        // R11: mismatched prefix discarded
        imm_pfx(10'd77);
        reg_w(12'h0B2, 2'd2);
        chk("R11 imm before reg", obs(), mk(0, 0, 0, 6'b000011, 24'h0000B2, 20'd0));
        short_w(6'd33);
        chk("R11 imm gone", obs(), mk(0, 0, 0, 6'd0, 24'd0, 20'd33));
        opd_pfx(12'h765, 2'd3, 1'b0);
        long_w(10'd900);
        chk("R11 opd before imm", obs(), mk(0, 0, 0, 6'd0, 24'd0, 20'd900));
        reg_w(12'h001, 2'd1);
        chk("R11 opd gone", obs(), mk(0, 0, 0, 6'b000001, 24'h000001, 20'd0));

        // R12: flush drops pending prefix and held word
        imm_pfx(10'd99);
        @(negedge clk) flush = 1'b1;
        #0.5 chk("R12 in_ready low in flush", 64'(in_ready), 64'd0);
        @(posedge clk) #1 flush = 1'b0;
        short_w(6'd4);
        chk("R12 prefix flushed", obs(), mk(0, 0, 0, 6'd0, 24'd0, 20'd4));
        out_ready = 1'b0;
        short_w(6'd8);
        @(negedge clk) flush = 1'b1;
        @(posedge clk) #1 flush = 1'b0;
        chk("R12 output flushed", 64'(out_valid), 64'd0);
        out_ready = 1'b1;

        // R13: backpressure holds the output
        out_ready = 1'b0;
        reg_w(12'h0A3, 2'd2);
        chk("R13 first held", obs(), mk(0, 0, 0, 6'b000011, 24'h0000A3, 20'd0));
        @(negedge clk);
        in_kind = 2'b00; in_opcode = 8'h07; in_imm = 10'd5; in_nops = 2'd0; in_valid = 1'b1;
        #0.5 chk("R13 in_ready low", 64'(in_ready), 64'd0);
        for (int c = 0; c < 2; c++) begin
            @(posedge clk) #1;
            chk("R13 stable under stall", obs(), mk(0, 0, 0, 6'b000011, 24'h0000A3, 20'd0));
        end
        @(negedge clk) out_ready = 1'b1;
        @(posedge clk) #1 in_valid = 1'b0;
        chk("R13 next word after release", obs(), mk(0, 0, 0, 6'd0, 24'd0, 20'd5));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule